// File: doc/BRIEF.md
# Selectable Arithmetic Micro-Operation Unit

This block is a purely combinational arithmetic stage of parameterised width. A single ripple-carry adder sums operand A with a second operand Y and a carry input. A two-bit operation select decides what Y is: operand B unchanged, the bitwise inverse of B, a word of zeros, or a word of ones. The select and the carry input together form eight codes. These codes yield seven distinct results: add, add with carry, subtract with borrow, subtract, increment, decrement and pass-through of A. Pass-through arises from two of the codes.

A datapath controller drives the select and carry lines in the same cycle as the operands. It captures the sum and the carry output in its own registers. The block holds no state, so there is no flow control at its edge. New operands may be presented on every cycle, and the result follows them directly.

Top module: `arith_mop_unit`

## Requirements
- R1: With `op_sel` = 2'b00, `{carry_out, result}` equals A + B + `carry_in`, taken as a (W+1)-bit unsigned sum.
- R2: With `op_sel` = 2'b01, `{carry_out, result}` equals A + (bitwise inverse of B) + `carry_in`. With `carry_in` = 1, `result` is A − B modulo 2^W. With `carry_in` = 0, it is A − B − 1 modulo 2^W.
- R3: With `op_sel` = 2'b10, `{carry_out, result}` equals A + `carry_in`. This passes A through when `carry_in` = 0 and increments A when `carry_in` = 1. Incrementing all ones gives `result` = 0 and `carry_out` = 1.
- R4: With `op_sel` = 2'b11, `{carry_out, result}` equals A + (2^W − 1) + `carry_in`. This decrements A when `carry_in` = 0 and passes A through when `carry_in` = 1. Decrementing zero gives all ones with `carry_out` = 0.
- R5: With `op_sel` = 2'b10 or 2'b11, `result` and `carry_out` do not depend on B.
- R6: With `op_sel` = 2'b01 and `carry_in` = 1, `carry_out` is 1 exactly when A ≥ B as unsigned numbers.
- R7: The codes (`op_sel` = 2'b10, `carry_in` = 0) and (`op_sel` = 2'b11, `carry_in` = 1) both give `result` = A.
- R8: The outputs are a function of the present inputs only. All-zero inputs give `result` = 0 and `carry_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Operand A, always the first adder input |
| op_b | input | W | Operand B, source for the second adder input |
| op_sel | input | 2 | Second-operand select: 00 B, 01 inverse of B, 10 zeros, 11 ones |
| carry_in | input | 1 | Carry into the least significant adder stage |
| result | output | W | Sum of A, the selected operand and the carry |
| carry_out | output | 1 | Carry out of the most significant adder stage |

## Verification
Every result of this block is due in the same cycle as the inputs that cause it, with zero register stages between them. The bench therefore changes inputs just after a rising clock edge and compares both outputs half a period later, at the falling edge, after the ripple chain has settled. Directed cases cover the increment wrap, the decrement underflow, the equal, greater and smaller subtract comparisons, and the two pass-through codes. Seeded random operands cover all eight select and carry codes.

// File: rtl/arith_mop_pkg.sv
package arith_mop_pkg;

  // Source of the second adder operand; the encoding is decoded by the selector.
  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NOTB = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

endpackage

// File: rtl/arith_mop_full_add.sv
module arith_mop_full_add (
  input  logic a_bit,
  input  logic y_bit,
  input  logic c_in,
  output logic s_bit,
  output logic c_out
);

  logic half_sum;

  always_comb begin
    half_sum = a_bit ^ y_bit;
    s_bit    = half_sum ^ c_in;
    c_out    = (a_bit & y_bit) | (half_sum & c_in);
  end

endmodule

// File: rtl/arith_mop_ysel.sv
module arith_mop_ysel
  import arith_mop_pkg::*;
#(
  parameter int W = 4
) (
  input  ysel_e          mode,
  input  logic [W-1:0]   b_in,
  output logic [W-1:0]   y_out
);

  for (genvar k = 0; k < W; k++) begin : g_lane
    always_comb begin
      unique case (mode)
        YSEL_B:    y_out[k] = b_in[k];
        YSEL_NOTB: y_out[k] = ~b_in[k];
        YSEL_ZERO: y_out[k] = 1'b0;
        YSEL_ONES: y_out[k] = 1'b1;
        default:   y_out[k] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/arith_mop_ripple.sv
module arith_mop_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] y_in,
  input  logic         c0,
  output logic [W-1:0] sum,
  output logic         c_top
);

  logic [W:0] chain;

  assign chain[0] = c0;

  for (genvar k = 0; k < W; k++) begin : g_stage
    arith_mop_full_add u_fa (
      .a_bit (a_in[k]),
      .y_bit (y_in[k]),
      .c_in  (chain[k]),
      .s_bit (sum[k]),
      .c_out (chain[k+1])
    );
  end

  assign c_top = chain[W];

endmodule

// File: rtl/arith_mop_unit.sv
module arith_mop_unit
  import arith_mop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);

  ysel_e        mode;
  logic [W-1:0] y_word;

  assign mode = ysel_e'(op_sel);

  arith_mop_ysel #(.W(W)) u_ysel (
    .mode  (mode),
    .b_in  (op_b),
    .y_out (y_word)
  );

  arith_mop_ripple #(.W(W)) u_add (
    .a_in  (op_a),
    .y_in  (y_word),
    .c0    (carry_in),
    .sum   (result),
    .c_top (carry_out)
  );

endmodule

// File: rtl/arith_mop_checker.sv
module arith_mop_checker #(
  parameter int W = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [1:0]   op_sel,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out
);

  localparam int WX = W + 1;
  localparam logic [WX-1:0] ALL_ONES_X = WX'((1 << W) - 1);

  logic [WX-1:0] a_x, b_x, nb_x, c_x, got;

  always_comb begin
    a_x  = {1'b0, op_a};
    b_x  = {1'b0, op_b};
    nb_x = ALL_ONES_X - b_x;
    c_x  = WX'(carry_in);
    got  = {carry_out, result};

    if (op_sel == 2'b00)
      assert_add_R1: assert (got == a_x + b_x + c_x)
        else $error("R1 add mismatch");
    if (op_sel == 2'b01)
      assert_sub_R2: assert (got == a_x + nb_x + c_x)
        else $error("R2 subtract mismatch");
    if (op_sel == 2'b10)
      assert_inc_R3: assert (got == a_x + c_x)
        else $error("R3 increment mismatch");
    if (op_sel == 2'b11)
      assert_dec_R4: assert (got == a_x + ALL_ONES_X + c_x)
        else $error("R4 decrement mismatch");
    if (op_sel == 2'b01 && carry_in)
      assert_cmp_R6: assert (carry_out == (op_a >= op_b))
        else $error("R6 compare mismatch");
    if ((op_sel == 2'b10 && !carry_in) || (op_sel == 2'b11 && carry_in))
      assert_pass_R7: assert (result == op_a)
        else $error("R7 pass-through mismatch");
  end

endmodule

bind arith_mop_unit arith_mop_checker #(.W(W)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .op_sel    (op_sel),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/sim_arith_mop_unit.sv
module sim_arith_mop_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int WD_LIMIT   = 20000;
  localparam int N_RANDOM   = 800;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [1:0]   op_sel = 2'b00;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arith_mop_unit #(.W(W)) u0 (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
  );

  // Expected {carry, sum} per requirement, from integer arithmetic.
  function automatic logic [W:0] expect_of(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [1:0] s, logic c);
    int unsigned top = (1 << W) - 1;
    int unsigned v;
    case (s)
      2'b00:   v = a + b + c;            // R1
      2'b01:   v = a + (top - b) + c;    // R2
      2'b10:   v = a + c;                // R3
      default: v = a + top + c;          // R4
    endcase
    return v[W:0];
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] s, logic c);
    @(posedge clk);
    op_a = a; op_b = b; op_sel = s; carry_in = c;
    #(CLK_PERIOD/2);
  endtask

  task automatic check(string tag, logic [W:0] actual, logic [W:0] expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h sel=%0b cin=%0b)",
               tag, actual, expected, op_a, op_b, op_sel, carry_in);
    end
  endtask

  task automatic run_vec(string tag, logic [W-1:0] a, logic [W-1:0] b,
                         logic [1:0] s, logic c);
    drive(a, b, s, c);
    check(tag, {carry_out, result}, expect_of(a, b, s, c));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W:0]   first;
    logic [W-1:0] ra, rb;
    logic [1:0]   rs;
    logic         rc;
    void'($urandom(32'd424242));
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R8: all-zero inputs give zero outputs with no history effect
    drive('0, '0, 2'b00, 1'b0);
    check("R8 zero", {carry_out, result}, '0);

    // R1: add and add with carry
    run_vec("R1 add", 4'h3, 4'h4, 2'b00, 1'b0);
    run_vec("R1 add carry wrap", 4'hF, 4'h1, 2'b00, 1'b1);

    // R2: subtract and subtract with borrow
    run_vec("R2 sub", 4'h9, 4'h3, 2'b01, 1'b1);
    run_vec("R2 sub borrow", 4'h9, 4'h3, 2'b01, 1'b0);

    // R6: carry_out flags A >= B
    drive(4'h5, 4'h5, 2'b01, 1'b1);
    check("R6 equal", {carry_out, result}, {1'b1, 4'h0});
    drive(4'h3, 4'h7, 2'b01, 1'b1);
    check("R6 smaller", {carry_out, result}, {1'b0, 4'hC});
    drive(4'hA, 4'h2, 2'b01, 1'b1);
    check("R6 greater", {4'b0, carry_out}, 5'd1);

    // R3: increment wraps all ones to zero with carry
    drive(4'hF, 4'h6, 2'b10, 1'b1);
    check("R3 inc wrap", {carry_out, result}, {1'b1, 4'h0});

    // R4: decrement of zero underflows without carry
    drive(4'h0, 4'h9, 2'b11, 1'b0);
    check("R4 dec zero", {carry_out, result}, {1'b0, 4'hF});

    // R7: both pass-through codes return A
    drive(4'hB, 4'h2, 2'b10, 1'b0);
    check("R7 pass sel10", {1'b0, result}, {1'b0, 4'hB});
    drive(4'hB, 4'h2, 2'b11, 1'b1);
    check("R7 pass sel11", {1'b0, result}, {1'b0, 4'hB});

    // R5: B has no effect when the selected operand is constant
    for (int s = 2; s < 4; s++) begin
      drive(4'h6, 4'h0, 2'(s), 1'b0);
      first = {carry_out, result};
      for (int bv = 1; bv < 16; bv++) begin
        drive(4'h6, 4'(bv), 2'(s), 1'b0);
        check("R5 B ignored", {carry_out, result}, first);
      end
    end

    // Seeded random sweep over all eight codes (R1 R2 R3 R4)
    for (int i = 0; i < N_RANDOM; i++) begin
      ra = 4'($urandom());
      rb = 4'($urandom());
      rs = 2'($urandom());
      rc = 1'($urandom());
      run_vec("R1/R2/R3/R4 random", ra, rb, rs, rc);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule